// File: doc/BRIEF.md
# Mixed-Aspect-Ratio Dual-Port RAM

A 4096-bit simple dual-port memory with one write port and one read port. Each port has its own clock. At elaboration each port picks one of four shapes: 16 bits by 256, 8 by 512, 4 by 1024 or 2 by 2048. The two ports may pick different shapes. Both views sit over one shared bit array, so a value written through a narrow port can be read back through a wide one, and the reverse also works.

Only the 16-bit write shape has a per-bit write mask. The read port captures the selected word into an output register. The register loads only on a read clock edge where both the clock enable and the read enable are high. Address and data ports are sized for the largest shape. A port set to a smaller shape ignores the bits it does not need, and the unused high bits of the read data are driven to zero.

Top module: `mixed_ratio_dpram`

## Requirements
- R1: While rst_n is low at a rising rclk edge, rdata becomes zero after that edge, whatever the read enables are.
- R2: With write shape 0 (16 bits, address bits [7:0]), a write stores wdata bit i only where wmask bit i is 0; a mask bit of 1 leaves the stored bit unchanged.
- R3: With write shapes 1, 2 and 3, the word is 8, 4 or 2 bits wide and the address is 9, 10 or 11 bits wide; wmask has no effect.
- R4: A word of width W at address A covers array bits A*W through A*W+W-1, so a read through any read shape returns exactly the bits the write port stored there.
- R5: The array changes only on a rising wclk edge where wce and we are both high.
- R6: rdata keeps its value across any rclk edge where rce or re is low.
- R7: When a read and a write hit the same bits on the same clock edge, the read returns the contents from before the write.
- R8: Address bits above bit 8+shape-1 are ignored on both ports.
- R9: wdata bits at or above the write width are ignored, and rdata bits at or above the read width are zero.
- R10: rdata shows the word addressed at a qualifying rclk edge right after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wce | input | 1 | Write clock enable |
| we | input | 1 | Write enable |
| waddr | input | 11 | Write address; only the low 8+WR_CFG bits are used |
| wdata | input | 16 | Write data, right-aligned |
| wmask | input | 16 | Per-bit write block (1 = keep); used only with write shape 0 |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset of the read register, synchronous to rclk |
| rce | input | 1 | Read clock enable |
| re | input | 1 | Read enable |
| raddr | input | 11 | Read address; only the low 8+RD_CFG bits are used |
| rdata | output | 16 | Registered read data, right-aligned, upper bits zero |

## Verification
Two instances are driven. One writes 16 bits with a mask and reads 2 bits. The other writes 4 bits and reads 8, so both wide-to-narrow and narrow-to-wide alignment are covered. Random addresses with random high bits test whether unused address bits are ignored. Random masks test whether the mask selects bits one by one rather than as a whole word. Forced read/write overlaps on the same edge separate a read-before-write design from a write-through one. Directed cases cover the enable combinations and the one-edge read timing.

// File: rtl/mr_pkg.sv
// Shared helpers for the mixed-aspect-ratio RAM.
// Assumes a shape code c selects a word of ROW_W >> c bits.
package mr_pkg;

    localparam int MR_SHAPE_MAX = 3;

    // Word width for a shape code.
    function automatic int mr_word_w(input int row_w, input int shape);
        return row_w >> shape;
    endfunction

    // Address width for a shape code.
    function automatic int mr_addr_w(input int row_aw, input int shape);
        return row_aw + shape;
    endfunction

endpackage

// File: rtl/mr_write_map.sv
// Write-side mapping: turns a port address into an array row, and turns
// data into a per-bit enable and aligned bits within that row.
// Assumes a word never crosses a row (ROW_W is a multiple of the word width).
module mr_write_map
    import mr_pkg::*;
#(
    parameter int ROW_W  = 16,
    parameter int ROW_AW = 8,
    parameter int ADDR_W = 11,
    parameter int CFG    = 0
) (
    input  logic [ADDR_W-1:0] waddr,
    input  logic [ROW_W-1:0]  wdata,
    input  logic [ROW_W-1:0]  wmask,
    input  logic              wce,
    input  logic              we,
    output logic [ROW_AW-1:0] row,
    output logic [ROW_W-1:0]  ben,
    output logic [ROW_W-1:0]  bits
);
    localparam int W     = mr_word_w(ROW_W, CFG);
    localparam int AW    = mr_addr_w(ROW_AW, CFG);
    localparam int OFF_W = $clog2(ROW_W);
    localparam logic [ROW_W-1:0] LOW = {ROW_W{1'b1}} >> (ROW_W - W);

    logic go;
    logic unused_w;

    // Both enables qualify a write.
    assign go = wce & we;

    // Bits that this shape does not use.
    assign unused_w = ^(waddr >> AW) ^ ^(wdata >> W) ^ ((CFG != 0) ? ^wmask : 1'b0);

    generate
        if (CFG == 0) begin : g_full
            // Full-row write; the mask blocks bits one by one.
            always_comb begin
                row  = waddr[ROW_AW-1:0];
                ben  = go ? ~wmask : '0;
                bits = wdata;
            end
        end else begin : g_narrow
            logic [CFG-1:0]   lane;
            logic [OFF_W-1:0] off;
            // Narrow write: low address bits pick the lane within a row.
            always_comb begin
                lane = waddr[CFG-1:0];
                row  = waddr[ROW_AW+CFG-1:CFG];
                off  = OFF_W'(lane) * OFF_W'(W);
                ben  = go ? (LOW << off) : '0;
                bits = (wdata & LOW) << off;
            end
        end
    endgenerate

endmodule

// File: rtl/mr_array.sv
// Bit storage as ROWS rows of ROW_W bits, with a per-bit enabled write on
// wclk and a combinational row read for the read port.
// Assumes no reset of the contents.
module mr_array #(
    parameter int ROW_W  = 16,
    parameter int ROW_AW = 8
) (
    input  logic              wclk,
    input  logic [ROW_AW-1:0] wrow,
    input  logic [ROW_W-1:0]  wben,
    input  logic [ROW_W-1:0]  wbits,
    input  logic [ROW_AW-1:0] rrow,
    output logic [ROW_W-1:0]  rrow_data
);
    localparam int ROWS = 1 << ROW_AW;

    logic [ROW_W-1:0] mem [ROWS];

    // Merge the enabled bits into the addressed row.
    always_ff @(posedge wclk) begin
        if (|wben) begin
            mem[wrow] <= (mem[wrow] & ~wben) | (wbits & wben);
        end
    end

    // Present the row the read port asks for.
    assign rrow_data = mem[rrow];

endmodule

// File: rtl/mr_read_sel.sv
// Read side: picks the row, extracts the word of the configured width and
// registers it on rclk when both read enables are high.
// Assumes the array row read is combinational, so the contents seen are
// those from before a write on the same edge.
module mr_read_sel
    import mr_pkg::*;
#(
    parameter int ROW_W  = 16,
    parameter int ROW_AW = 8,
    parameter int ADDR_W = 11,
    parameter int CFG    = 0
) (
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              rce,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [ROW_AW-1:0] rrow,
    input  logic [ROW_W-1:0]  rrow_data,
    output logic [ROW_W-1:0]  rdata
);
    localparam int W     = mr_word_w(ROW_W, CFG);
    localparam int AW    = mr_addr_w(ROW_AW, CFG);
    localparam int OFF_W = $clog2(ROW_W);
    localparam logic [ROW_W-1:0] LOW = {ROW_W{1'b1}} >> (ROW_W - W);

    logic [OFF_W-1:0] off;
    logic             unused_r;

    // Address bits that this shape does not use.
    assign unused_r = ^(raddr >> AW);

    generate
        if (CFG == 0) begin : g_full
            // The whole row is the word.
            always_comb begin
                rrow = raddr[ROW_AW-1:0];
                off  = '0;
            end
        end else begin : g_narrow
            // Low address bits pick the lane.
            always_comb begin
                rrow = raddr[ROW_AW+CFG-1:CFG];
                off  = OFF_W'(raddr[CFG-1:0]) * OFF_W'(W);
            end
        end
    endgenerate

    // Output register: reset, load on both enables, otherwise hold.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rce && re) begin
            rdata <= (rrow_data >> off) & LOW;
        end
    end

endmodule

// File: rtl/mixed_ratio_dpram.sv
// Simple dual-port 4096-bit RAM. The write and read shapes are picked on
// their own through WR_CFG and RD_CFG (0..3: 16, 8, 4 or 2 bits wide).
// Assumes that rst_n is held low for at least one rclk edge.
module mixed_ratio_dpram #(
    parameter int ROW_W  = 16,
    parameter int ROW_AW = 8,
    parameter int WR_CFG = 0,
    parameter int RD_CFG = 0,
    localparam int ADDR_W = ROW_AW + $clog2(ROW_W) - 1
) (
    input  logic              wclk,
    input  logic              wce,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [ROW_W-1:0]  wdata,
    input  logic [ROW_W-1:0]  wmask,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              rce,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [ROW_W-1:0]  rdata
);
    logic [ROW_AW-1:0] wr_row;
    logic [ROW_W-1:0]  wr_ben;
    logic [ROW_W-1:0]  wr_bits;
    logic [ROW_AW-1:0] rd_row;
    logic [ROW_W-1:0]  rd_row_data;

    mr_write_map #(
        .ROW_W(ROW_W), .ROW_AW(ROW_AW), .ADDR_W(ADDR_W), .CFG(WR_CFG)
    ) u_wmap (
        .waddr(waddr), .wdata(wdata), .wmask(wmask), .wce(wce), .we(we),
        .row(wr_row), .ben(wr_ben), .bits(wr_bits)
    );

    mr_array #(
        .ROW_W(ROW_W), .ROW_AW(ROW_AW)
    ) u_array (
        .wclk(wclk), .wrow(wr_row), .wben(wr_ben), .wbits(wr_bits),
        .rrow(rd_row), .rrow_data(rd_row_data)
    );

    mr_read_sel #(
        .ROW_W(ROW_W), .ROW_AW(ROW_AW), .ADDR_W(ADDR_W), .CFG(RD_CFG)
    ) u_rsel (
        .rclk(rclk), .rst_n(rst_n), .rce(rce), .re(re), .raddr(raddr),
        .rrow(rd_row), .rrow_data(rd_row_data), .rdata(rdata)
    );

endmodule

// File: rtl/mr_checker.sv
// Property checker for mixed_ratio_dpram, attached with bind.
// Watches the ports and the write-enable vector that the write map drives.
module mr_checker #(
    parameter int ROW_W  = 16,
    parameter int WR_CFG = 0,
    parameter int RD_CFG = 0
) (
    input logic             wclk,
    input logic             rclk,
    input logic             rst_n,
    input logic             wce,
    input logic             we,
    input logic [ROW_W-1:0] wmask,
    input logic             rce,
    input logic             re,
    input logic [ROW_W-1:0] rdata,
    input logic [ROW_W-1:0] wben
);
    localparam int WR_W = ROW_W >> WR_CFG;
    localparam int RD_W = ROW_W >> RD_CFG;
    localparam logic [ROW_W-1:0] RD_LOW = {ROW_W{1'b1}} >> (ROW_W - RD_W);

    a_r1_reset_clear: assert property (@(posedge rclk)
        !rst_n |=> rdata == '0);

    a_r5_no_write_unless_enabled: assert property (@(posedge wclk) disable iff (!rst_n)
        !(wce && we) |-> wben == '0);

    a_r6_hold_when_idle: assert property (@(posedge rclk) disable iff (!rst_n)
        !(rce && re) |=> $stable(rdata));

    a_r9_upper_read_zero: assert property (@(posedge rclk) disable iff (!rst_n)
        (rdata & ~RD_LOW) == '0);

    generate
        if (WR_CFG == 0) begin : g_mask
            a_r2_mask_per_bit: assert property (@(posedge wclk) disable iff (!rst_n)
                (wce && we) |-> wben == ~wmask);
        end else begin : g_lane
            a_r3_lane_width: assert property (@(posedge wclk) disable iff (!rst_n)
                (wce && we) |-> $countones(wben) == WR_W);
        end
    endgenerate

endmodule

bind mixed_ratio_dpram mr_checker #(
    .ROW_W(ROW_W), .WR_CFG(WR_CFG), .RD_CFG(RD_CFG)
) u_chk (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wce(wce), .we(we),
    .wmask(wmask), .rce(rce), .re(re), .rdata(rdata), .wben(wr_ben)
);

// File: tb/mixed_ratio_dpram_test.sv
`timescale 1ns/1ps
// Bench: uut writes 16 bits with a mask and reads 2 bits; uut_b writes 4
// bits and reads 8. Bit-level models predict every read.
module mixed_ratio_dpram_test;
    localparam int WA = 0, RA = 3, WB = 2, RB = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        a_wce, a_we, a_rce, a_re, b_wce, b_we, b_rce, b_re;
    logic [10:0] a_waddr, a_raddr, b_waddr, b_raddr;
    logic [15:0] a_wdata, a_wmask, a_rdata, b_wdata, b_wmask, b_rdata;

    logic [4095:0] ma = '0, mb = '0;
    logic [15:0]   ea = '0, eb = '0;
    int checks = 0, fails = 0;

    mixed_ratio_dpram #(.WR_CFG(WA), .RD_CFG(RA)) uut (
        .wclk(clk), .wce(a_wce), .we(a_we), .waddr(a_waddr), .wdata(a_wdata),
        .wmask(a_wmask), .rclk(clk), .rst_n(rst_n), .rce(a_rce), .re(a_re),
        .raddr(a_raddr), .rdata(a_rdata));

    mixed_ratio_dpram #(.WR_CFG(WB), .RD_CFG(RB)) uut_b (
        .wclk(clk), .wce(b_wce), .we(b_we), .waddr(b_waddr), .wdata(b_wdata),
        .wmask(b_wmask), .rclk(clk), .rst_n(rst_n), .rce(b_rce), .re(b_re),
        .raddr(b_raddr), .rdata(b_rdata));

    function automatic int eff(input int cfg, input logic [10:0] ad);
        return int'(ad) & ((1 << (8 + cfg)) - 1);
    endfunction

    function automatic logic [15:0] mread(input logic [4095:0] m, input int cfg,
                                          input logic [10:0] ad);
        int w = 16 >> cfg;
        int b = eff(cfg, ad) * w;
        logic [15:0] r = '0;
        for (int i = 0; i < w; i++) r[i] = m[b + i];
        return r;
    endfunction

    function automatic logic [4095:0] mwrite(input logic [4095:0] m, input int cfg,
            input logic [10:0] ad, input logic [15:0] d, input logic [15:0] k);
        int w = 16 >> cfg;
        int b = eff(cfg, ad) * w;
        for (int i = 0; i < w; i++)
            if (cfg != 0 || !k[i]) m[b + i] = d[i];
        return m;
    endfunction

    function automatic bit overlap(input int wc, input int rc, input logic [10:0] wa,
                                   input logic [10:0] ra);
        int ww = 16 >> wc, rw = 16 >> rc;
        int ws = eff(wc, wa) * ww, rs = eff(rc, ra) * rw;
        return (rs < ws + ww) && (ws < rs + rw);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string autotag(input logic rce, input logic re, input logic wce,
            input logic we, input int wc, input int rc, input logic [10:0] wa,
            input logic [10:0] ra);
        if (!(rce && re)) return "R6";
        if (wce && we && overlap(wc, rc, wa, ra)) return "R7";
        return "R4";
    endfunction

    // One clock: predict with the old contents, update models, check after the edge.
    task automatic step(input string tag);
        string ta, tb;
        ta = (tag == "auto") ? autotag(a_rce, a_re, a_wce, a_we, WA, RA, a_waddr, a_raddr) : tag;
        tb = (tag == "auto") ? autotag(b_rce, b_re, b_wce, b_we, WB, RB, b_waddr, b_raddr) : tag;
        if (!rst_n) begin
            ea = '0; eb = '0;
        end else begin
            if (a_rce && a_re) ea = mread(ma, RA, a_raddr);
            if (b_rce && b_re) eb = mread(mb, RB, b_raddr);
        end
        if (a_wce && a_we) ma = mwrite(ma, WA, a_waddr, a_wdata, a_wmask);
        if (b_wce && b_we) mb = mwrite(mb, WB, b_waddr, b_wdata, b_wmask);
        @(posedge clk);
        #2;
        if (tag != "") begin
            chk({ta, " uut"}, a_rdata, ea);
            chk({tb, " uut_b"}, b_rdata, eb);
        end
        @(negedge clk);
    endtask

    task automatic idle();
        a_wce = 0; a_we = 0; a_rce = 0; a_re = 0;
        b_wce = 0; b_we = 0; b_rce = 0; b_re = 0;
        a_wmask = '0; b_wmask = '0;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        idle();
        a_waddr = '0; a_raddr = '0; a_wdata = '0;
        b_waddr = '0; b_raddr = '0; b_wdata = '0;
        @(negedge clk);
        step(""); step("");
        // R1: reset wins over active read enables
        a_rce = 1; a_re = 1; b_rce = 1; b_re = 1;
        step("R1");
        rst_n = 1'b1;
        idle();
        // Fill both arrays through the write ports
        for (int i = 0; i < 1024; i++) begin
            a_wce = 1; a_we = 1; a_waddr = 11'(i % 256); a_wdata = 16'($urandom);
            b_wce = 1; b_we = 1; b_waddr = 11'(i); b_wdata = 16'($urandom);
            step("");
        end
        idle();
        // R10: not visible before the edge, visible right after
        a_rce = 1; a_re = 1; a_raddr = 11'd5; b_rce = 1; b_re = 1; b_raddr = 11'd77;
        #1;
        chk("R10 uut pre-edge", a_rdata, ea);
        chk("R10 uut_b pre-edge", b_rdata, eb);
        @(negedge clk);
        step("R10");
        // R6: either enable low holds the output
        a_raddr = 11'd300; b_raddr = 11'd301; a_re = 0; b_re = 0;
        step("R6");
        a_re = 1; b_re = 1; a_rce = 0; b_rce = 0;
        step("R6");
        idle();
        // R5: one enable alone writes nothing
        a_wce = 1; a_waddr = 11'd9; a_wdata = 16'h1234;
        b_we = 1; b_waddr = 11'd18; b_wdata = 16'h000F;
        step("");
        idle();
        a_rce = 1; a_re = 1; a_raddr = {8'd9, 3'd2};
        b_rce = 1; b_re = 1; b_raddr = 11'd9;
        step("R5");
        idle();
        // R2: masked full-width write, read back in 2-bit slices
        a_wce = 1; a_we = 1; a_waddr = 11'd20; a_wdata = 16'hA5C3; a_wmask = 16'hFF00;
        step("");
        idle();
        for (int k = 0; k < 8; k++) begin
            a_rce = 1; a_re = 1; a_raddr = 11'(20 * 8 + k);
            step("R2");
        end
        idle();
        // R3 and R9: narrow write with stray upper data and a mask
        b_wce = 1; b_we = 1; b_waddr = 11'd100; b_wdata = 16'hFFF6; b_wmask = 16'hFFFF;
        step("");
        idle();
        b_rce = 1; b_re = 1; b_raddr = 11'd50;
        step("R3");
        step("R9");
        idle();
        // R8: upper address bits on both ports are ignored
        b_wce = 1; b_we = 1; b_waddr = 11'h407; b_wdata = 16'h0009;
        a_wce = 1; a_we = 1; a_waddr = 11'h733; a_wdata = 16'h5AA5;
        step("");
        idle();
        b_rce = 1; b_re = 1; b_raddr = 11'h603;
        a_rce = 1; a_re = 1; a_raddr = {8'h33, 3'd7};
        step("R8");
        idle();
        // R7: same-edge write and read of the same bits return old data
        b_wce = 1; b_we = 1; b_waddr = 11'd40; b_wdata = 16'h000C;
        b_rce = 1; b_re = 1; b_raddr = 11'd20;
        a_wce = 1; a_we = 1; a_waddr = 11'd60; a_wdata = 16'hFFFF;
        a_rce = 1; a_re = 1; a_raddr = {8'd60, 3'd0};
        step("R7");
        idle();
        b_rce = 1; b_re = 1; a_rce = 1; a_re = 1;
        step("R7");
        idle();
        // Random traffic with forced overlaps
        for (int n = 0; n < 3000; n++) begin
            a_wce = ($urandom % 4) != 0; a_we = ($urandom % 4) != 0;
            a_rce = ($urandom % 4) != 0; a_re = ($urandom % 4) != 0;
            b_wce = ($urandom % 4) != 0; b_we = ($urandom % 4) != 0;
            b_rce = ($urandom % 4) != 0; b_re = ($urandom % 4) != 0;
            a_waddr = 11'($urandom); a_wdata = 16'($urandom); a_wmask = 16'($urandom);
            b_waddr = 11'($urandom); b_wdata = 16'($urandom); b_wmask = 16'($urandom);
            a_raddr = 11'($urandom); b_raddr = 11'($urandom);
            if ($urandom % 4 == 0) begin
                a_raddr = {a_waddr[7:0], 3'($urandom)};
                b_raddr = {1'b0, b_waddr[10:1]};
            end
            step("auto");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule